// File: doc/BRIEF.md
# Flash Write-Cycle Qualifier

This block sits at the bus edge of a flash device model. It watches the three active-low control pins: chip enable, write enable and output enable. A write cycle counts only when chip enable and write enable are both low while output enable is high. For each such cycle the block gives the command decoder one single-clock write strobe, along with the address and data captured for that cycle.

All three pins are oversampled on a fast clock. A pin's new level is accepted only after it has stayed the same for `FILT_SAMPLES` consecutive samples, so short noise pulses are discarded. The address is captured when the second of the two enables goes low, which is the later falling edge. The data is captured when the first of them goes high, which is the earlier rising edge. Two inputs stand in for the analog detectors: a power-on pulse and a supply-good flag. Either one locks the qualifier and raises a reset request to the downstream state machine. After a lock, writes are accepted again only once an idle bus has been seen, meaning write enable or chip enable is high.

Top module: `flash_wr_qual`

## Requirements
- R1: While `rst` is high, `wr_stb` is 0, and from the first clock edge of reset onward `cmd_rst_req` is 1.
- R2: A cycle in which `ce_n` and `we_n` are both low with `oe_n` high, then ends by `we_n` or `ce_n` rising, produces exactly one `wr_stb` pulse of one clock.
- R3: A cycle in which `ce_n` and `we_n` are low while `oe_n` is low the whole time produces no `wr_stb`.
- R4: `wr_addr` holds the `addr_in` value present when the later of `we_n`/`ce_n` fell. An address value driven after only the first enable fell is replaced.
- R5: `wr_data` holds the `data_in` value present when the earlier of `we_n`/`ce_n` rose. Data changed after that edge but before the other enable rises is not used.
- R6: A low pulse on `we_n` or `ce_n`, or a low pulse on `oe_n` during a cycle, shorter than `FILT_SAMPLES` clock samples, has no effect. It neither creates nor cancels a strobe.
- R7: If `por` ends while `we_n` and `ce_n` are low and `oe_n` is high, the following rise of `we_n` gives no strobe. The next complete cycle gives a strobe.
- R8: While `supply_ok` is 0, no cycle gives a strobe. One clock after `supply_ok` goes to 0, `cmd_rst_req` is 1. After the supply recovers, a complete cycle gives a strobe again.
- R9: If `oe_n` goes low for `FILT_SAMPLES` samples or more during a cycle, the cycle is dropped without a strobe. A return of `oe_n` high before `we_n`/`ce_n` go high does not restart it.
- R10: While `por` is 1, `cmd_rst_req` is 1 one clock later and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| por | input | 1 | Power-on indication, high during power-up |
| supply_ok | input | 1 | High when supply is above the lockout level |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_in | input | ADDR_W | Address bus |
| data_in | input | DATA_W | Data bus |
| wr_stb | output | 1 | One-clock pulse per accepted write cycle |
| wr_addr | output | ADDR_W | Captured address of the last accepted cycle |
| wr_data | output | DATA_W | Captured data of the last accepted cycle |
| cmd_rst_req | output | 1 | Request to return the command logic to array read |

## Verification
The hardest states to reach are the ones where the pins already look like a write when the qualifier loses its lock. One case is a power-up that ends with both enables held low. The other is an output-enable drop that is long enough to abort a cycle and then returns high while both enables stay low. The stimulus holds the enables low through the whole `por` pulse, and separately through an output-enable drop and recovery. It then checks that releasing the enables yields no strobe and that the next full cycle does. Glitch rejection is tested with pulses one sample short of the filter length, on each pin in turn.

// File: rtl/flash_wr_qual_pkg.sv
package flash_wr_qual_pkg;

    typedef enum logic [1:0] {
        ST_LOCK   = 2'd0,
        ST_READY  = 2'd1,
        ST_ACTIVE = 2'd2
    } wq_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } wq_pins_t;

    localparam int PIN_CE = 2;
    localparam int PIN_WE = 1;
    localparam int PIN_OE = 0;
    localparam int NUM_PINS = 3;

    function automatic logic pins_write(input wq_pins_t p);
        return !p.ce_n && !p.we_n && p.oe_n;
    endfunction

    function automatic logic pins_idle(input wq_pins_t p);
        return p.ce_n || p.we_n;
    endfunction

endpackage

// File: rtl/wq_pin_filter.sv
module wq_pin_filter #(
    parameter int FILT_SAMPLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int CW = (FILT_SAMPLES > 1) ? $clog2(FILT_SAMPLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_SAMPLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b1;
            cnt   <= '0;
        end else if (raw == level) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            level <= raw;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: the filtered level only moves to a value the raw pin was showing
    p_level_follows_raw_r6: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> ($past(raw) == level));

endmodule

// File: rtl/wq_cycle_fsm.sv
module wq_cycle_fsm
    import flash_wr_qual_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blocked,
    input  wq_pins_t          pins,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    wq_state_e         state, state_nx;
    logic [ADDR_W-1:0] addr_hold;
    logic              start_cyc, end_cyc;

    always_comb begin
        state_nx  = state;
        start_cyc = 1'b0;
        end_cyc   = 1'b0;
        if (blocked) begin
            state_nx = ST_LOCK;
        end else begin
            unique case (state)
                ST_LOCK:   if (pins_idle(pins)) state_nx = ST_READY;
                ST_READY:  if (pins_write(pins)) begin
                               state_nx  = ST_ACTIVE;
                               start_cyc = 1'b1;
                           end
                ST_ACTIVE: if (!pins.oe_n) begin
                               state_nx = ST_LOCK;
                           end else if (pins_idle(pins)) begin
                               state_nx = ST_READY;
                               end_cyc  = 1'b1;
                           end
                default:   state_nx = ST_LOCK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_LOCK;
            wr_stb    <= 1'b0;
            addr_hold <= '0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            state  <= state_nx;
            wr_stb <= end_cyc;
            if (start_cyc) addr_hold <= addr_in;
            if (end_cyc) begin
                wr_addr <= addr_hold;
                wr_data <= data_in;
            end
        end
    end

    // R2: strobe lasts one clock
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);
    // R2: strobe only follows an active cycle
    p_stb_after_active_r2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ($past(state) == ST_ACTIVE));
    // R3: a cycle is entered only with write enables low and output enable high
    p_entry_qualified_r3: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ACTIVE) && ($past(state) != ST_ACTIVE)) |-> $past(pins_write(pins)));
    // R8: lock forces idle and no strobe
    p_blocked_locks_r8: assert property (@(posedge clk) disable iff (rst)
        blocked |=> ((state == ST_LOCK) && !wr_stb));

endmodule

// File: rtl/flash_wr_qual.sv
module flash_wr_qual
    import flash_wr_qual_pkg::*;
#(
    parameter int ADDR_W       = 19,
    parameter int DATA_W       = 16,
    parameter int FILT_SAMPLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              supply_ok,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cmd_rst_req
);
    logic [NUM_PINS-1:0] raw_vec, filt_vec;
    wq_pins_t            pins_f;
    logic                blocked;

    assign raw_vec[PIN_CE] = ce_n;
    assign raw_vec[PIN_WE] = we_n;
    assign raw_vec[PIN_OE] = oe_n;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_filt
        wq_pin_filter #(.FILT_SAMPLES(FILT_SAMPLES)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_vec[i]),
            .level (filt_vec[i])
        );
    end

    assign pins_f.ce_n = filt_vec[PIN_CE];
    assign pins_f.we_n = filt_vec[PIN_WE];
    assign pins_f.oe_n = filt_vec[PIN_OE];
    assign blocked     = por || !supply_ok;

    wq_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .blocked (blocked),
        .pins    (pins_f),
        .addr_in (addr_in),
        .data_in (data_in),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) cmd_rst_req <= 1'b1;
        else     cmd_rst_req <= blocked;
    end

    // R8: low supply requests a command-logic reset
    p_low_supply_req_r8: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> cmd_rst_req);
    // R10: power-on requests a reset and suppresses strobes
    p_por_req_r10: assert property (@(posedge clk) disable iff (rst)
        por |=> (cmd_rst_req && !wr_stb));

endmodule

// File: tb/flash_wr_qual_test.sv
module flash_wr_qual_test;
    localparam int AW = 19;
    localparam int DW = 16;
    localparam int NF = 4;

    logic          clk = 1'b0;
    logic          rst, por, supply_ok, ce_n, we_n, oe_n;
    logic [AW-1:0] addr_in;
    logic [DW-1:0] data_in;
    logic          wr_stb, cmd_rst_req;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_chk = 0, n_bad = 0, stb_cnt = 0;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_data;
    bit done = 0;

    always #10 clk = ~clk;

    flash_wr_qual #(.ADDR_W(AW), .DATA_W(DW), .FILT_SAMPLES(NF)) uut (
        .clk(clk), .rst(rst), .por(por), .supply_ok(supply_ok),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr_in(addr_in), .data_in(data_in),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_rst_req(cmd_rst_req));

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt   <= stb_cnt + 1;
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic full_cycle(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr_in = a; data_in = d;
        ce_n = 0; wait_n(2); we_n = 0; wait_n(NF + 4);
        we_n = 1; wait_n(NF + 4); ce_n = 1; wait_n(NF + 4);
    endtask

    task automatic t_reset;
        rst = 1; por = 0; supply_ok = 1; ce_n = 1; we_n = 1; oe_n = 1;
        addr_in = '0; data_in = '0;
        wait_n(3);
        chk("R1 stb in reset", wr_stb, 0);
        chk("R1 req in reset", cmd_rst_req, 1);
        rst = 0; wait_n(NF + 4);
        chk("R1 req after reset", cmd_rst_req, 0);
    endtask

    task automatic t_basic;
        int s0 = stb_cnt;
        full_cycle(19'h1_2345, 16'hBEEF);
        chk("R2 one strobe", stb_cnt - s0, 1);
        chk("R2 addr", last_addr, 19'h1_2345);
        chk("R2 data", last_data, 16'hBEEF);
        s0 = stb_cnt;
        full_cycle(19'h0_0AA5, 16'h1357);
        chk("R2 second strobe", stb_cnt - s0, 1);
    endtask

    task automatic t_oe_low;
        int s0 = stb_cnt;
        oe_n = 0; wait_n(NF + 2);
        full_cycle(19'h7, 16'h7);
        oe_n = 1; wait_n(NF + 4);
        chk("R3 oe low blocks", stb_cnt - s0, 0);
    endtask

    task automatic t_latch_edges;
        int s0 = stb_cnt;
        addr_in = 19'h0_1111; data_in = 16'hAAAA;
        we_n = 0; wait_n(NF + 3);
        addr_in = 19'h0_2222;
        ce_n = 0; wait_n(NF + 3);
        addr_in = 19'h0_3333;
        ce_n = 1; wait_n(NF + 3);
        data_in = 16'h5555;
        we_n = 1; wait_n(NF + 4);
        chk("R4 later fall addr", last_addr, 19'h0_2222);
        chk("R5 earlier rise data", last_data, 16'hAAAA);
        chk("R4 strobe count", stb_cnt - s0, 1);
    endtask

    task automatic t_glitch;
        int s0 = stb_cnt;
        ce_n = 0; wait_n(NF + 3);
        we_n = 0; wait_n(NF - 1); we_n = 1; wait_n(NF + 4);
        ce_n = 1; wait_n(NF + 3);
        chk("R6 we glitch", stb_cnt - s0, 0);
        we_n = 0; wait_n(NF + 3);
        ce_n = 0; wait_n(NF - 1); ce_n = 1; wait_n(NF + 4);
        we_n = 1; wait_n(NF + 3);
        chk("R6 ce glitch", stb_cnt - s0, 0);
        addr_in = 19'h4444; data_in = 16'h4444;
        ce_n = 0; we_n = 0; wait_n(NF + 3);
        oe_n = 0; wait_n(NF - 1); oe_n = 1; wait_n(NF + 3);
        we_n = 1; ce_n = 1; wait_n(NF + 4);
        chk("R6 oe glitch keeps cycle", stb_cnt - s0, 1);
    endtask

    task automatic t_abort;
        int s0 = stb_cnt;
        ce_n = 0; we_n = 0; wait_n(NF + 3);
        oe_n = 0; wait_n(NF + 4);
        oe_n = 1; wait_n(NF + 4);
        we_n = 1; wait_n(NF + 4);
        ce_n = 1; wait_n(NF + 4);
        chk("R9 abort no strobe", stb_cnt - s0, 0);
        full_cycle(19'h5A5A, 16'hC0DE);
        chk("R9 recover", stb_cnt - s0, 1);
    endtask

    task automatic t_powerup;
        int s0 = stb_cnt;
        por = 1; ce_n = 0; we_n = 0; oe_n = 1; wait_n(NF + 6);
        chk("R10 req during por", cmd_rst_req, 1);
        por = 0; wait_n(NF + 4);
        we_n = 1; wait_n(NF + 4);
        ce_n = 1; wait_n(NF + 4);
        chk("R7 first rise rejected", stb_cnt - s0, 0);
        full_cycle(19'h0_0F0F, 16'h0F0F);
        chk("R7 next cycle accepted", stb_cnt - s0, 1);
    endtask

    task automatic t_supply;
        int s0 = stb_cnt;
        supply_ok = 0; wait_n(1);
        chk("R8 req on low supply", cmd_rst_req, 1);
        full_cycle(19'h0_0BAD, 16'h0BAD);
        chk("R8 no strobe while low", stb_cnt - s0, 0);
        supply_ok = 1; wait_n(2);
        chk("R8 req clears", cmd_rst_req, 0);
        full_cycle(19'h0_0600D, 16'h600D);
        chk("R8 strobe after recovery", stb_cnt - s0, 1);
        chk("R8 addr after recovery", last_addr, 19'h0_600D);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_basic;
        t_oe_low;
        t_latch_edges;
        t_glitch;
        t_abort;
        t_powerup;
        t_supply;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule